// File: doc/BRIEF.md
# Scoreboarded Register-Read Stage with Execute Bypass

This block sits between decode and execute in an in-order pipeline. Each cycle it looks at one decoded instruction (a destination index, a flag saying whether the instruction writes that destination, and two source indices). It drives the two read addresses of an external register file, checks a per-register busy vector, and compares each source against a one-cycle bypass bus that the execute stage drives with a freshly computed ALU result. If nothing blocks it, the instruction issues: its operands and destination land in the stage's output register on the next clock edge. If the instruction writes a register, that register is marked busy at the same edge.

Writeback drives a dedicated clear port that marks one register available again. The clear is direct, not queued, and the register file write that goes with it is expected at the same edge, so the next cycle reads the new value. The stage stalls on a write-after-write conflict (its destination still busy) and on any busy source that the bypass bus does not carry in the same cycle. While stalled the upstream holds the instruction, `in_ready` is low, and nothing issues.

Top module: `regrd_stage`

## Requirements
- R1: After reset no output is valid and every register is available, so the first instruction issues at once whatever registers it names.
- R2: Issuing an instruction with `in_writes` high and a nonzero destination marks that destination busy from the next cycle on; a later reader of it then stalls unless bypassed.
- R3: An instruction with `in_writes` high whose nonzero destination is busy stalls (`in_ready` low). With `in_writes` low the destination is not checked.
- R4: The stage stalls when either nonzero source is busy and the bypass bus (`byp_valid` high) does not carry that index in the same cycle; a bypass match on one busy source does not release a second busy source.
- R5: When `byp_valid` is high and `byp_idx` equals a nonzero source index, `byp_data` becomes that operand in place of the register-file value, whether or not the register is busy.
- R6: The bypass holds no state: a match lifts a stall only in the cycle the bus carries it.
- R7: A writeback clear (`wb_clr_valid`, `wb_clr_idx`) makes that register available from the next cycle; the stall check in the clear's own cycle still sees it busy.
- R8: Register 0 is never busy, never causes a stall, and always reads as zero, even when the register file or the bypass bus offers another value for it.
- R9: In a stalled cycle nothing issues: `out_valid` is low in the following cycle and the busy state changes only through writeback clears.
- R10: If a clear and a new busy mark hit the same register in one cycle, the register stays busy.
- R11: `out_valid` in a cycle equals `in_valid && in_ready` of the cycle before; with it come the destination, the write flag and both operands of the issued instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Decoded instruction present |
| in_ready | output | 1 | High when the instruction issues this cycle (no stall) |
| in_writes | input | 1 | Instruction writes its destination |
| in_dst | input | IDX_W | Destination register index |
| in_src_a | input | IDX_W | First source index |
| in_src_b | input | IDX_W | Second source index |
| rf_addr_a | output | IDX_W | Register file read address, first operand |
| rf_addr_b | output | IDX_W | Register file read address, second operand |
| rf_data_a | input | DATA_W | Register file read data, first operand |
| rf_data_b | input | DATA_W | Register file read data, second operand |
| byp_valid | input | 1 | Execute bypass carries a result this cycle |
| byp_idx | input | IDX_W | Register index of the bypassed result |
| byp_data | input | DATA_W | Bypassed result value |
| wb_clr_valid | input | 1 | Writeback marks a register available |
| wb_clr_idx | input | IDX_W | Register index made available |
| out_valid | output | 1 | Issued instruction held in the output register |
| out_writes | output | 1 | Write flag of the issued instruction |
| out_dst | output | IDX_W | Destination of the issued instruction |
| out_opnd_a | output | DATA_W | First operand value |
| out_opnd_b | output | DATA_W | Second operand value |

## Verification
On every cycle the assertions check the hazard rules against the live busy vector: a busy destination or an unbypassed busy source forces `in_ready` low, register 0 is never busy, an issued writer is busy next cycle, a collision of mark and clear leaves the register busy, and a cycle without issue or clear leaves the busy vector untouched. Only the bench's scenarios show that the operand values are right (bypass data in place of stale register data, zero for register 0), that a bypass match lasts exactly one cycle, and that a clear unblocks a waiting reader one cycle later with the newly written value; a behavioural model checked on every clock, fed both directed sequences and a long random run, covers these.

// File: rtl/regrd_pkg.sv
// Package: shared types of the register-read stage.
// Assumes nothing beyond being compiled before the stage's modules.
package regrd_pkg;

    // Where an operand value comes from.
    typedef enum logic [1:0] {
        OPND_FROM_RF   = 2'd0,
        OPND_FROM_BYP  = 2'd1,
        OPND_FROM_ZERO = 2'd2
    } opnd_src_e;

    // Number of source operands handled per instruction.
    localparam int unsigned NUM_OPNDS = 2;

endpackage

// File: rtl/regrd_scoreboard.sv
// Module: per-register busy bits.
// A set marks a register busy, a clear marks it available; when both hit
// the same register in one cycle the set wins. Register 0 never becomes busy.
// Assumes at most one set and one clear per cycle.
module regrd_scoreboard #(
    parameter int unsigned NUM_REGS = 32,
    parameter int unsigned IDX_W    = $clog2(NUM_REGS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                set_en,
    input  logic [IDX_W-1:0]    set_idx,
    input  logic                clr_en,
    input  logic [IDX_W-1:0]    clr_idx,
    output logic [NUM_REGS-1:0] busy_o
);

    logic [NUM_REGS-1:0] busy_q;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_bit
        if (g == 0) begin : g_zero
            // Register 0 is hard-wired available.
            always_ff @(posedge clk) begin
                busy_q[g] <= 1'b0;
            end
        end else begin : g_reg
            logic set_hit;
            logic clr_hit;
            assign set_hit = set_en && (set_idx == IDX_W'(g));
            assign clr_hit = clr_en && (clr_idx == IDX_W'(g));
            // Track busy state; set has priority over clear.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    busy_q[g] <= 1'b0;
                end else if (set_hit) begin
                    busy_q[g] <= 1'b1;
                end else if (clr_hit) begin
                    busy_q[g] <= 1'b0;
                end
            end
        end
    end

    assign busy_o = busy_q;

endmodule

// File: rtl/regrd_operand.sv
// Module: operand selection for one source.
// Picks zero for register 0, bypass data on an index match, otherwise the
// register file data, and reports whether this source blocks issue
// (busy and not carried by the bypass bus this cycle).
// Assumes the register file read data is combinational on the address.
module regrd_operand
    import regrd_pkg::*;
#(
    parameter int unsigned IDX_W  = 5,
    parameter int unsigned DATA_W = 32
) (
    input  logic [IDX_W-1:0]  src_idx,
    input  logic              src_busy,
    input  logic [DATA_W-1:0] rf_data,
    input  logic              byp_valid,
    input  logic [IDX_W-1:0]  byp_idx,
    input  logic [DATA_W-1:0] byp_data,
    output logic [DATA_W-1:0] value_o,
    output logic              blocked_o
);

    opnd_src_e sel;
    logic      is_zero;
    logic      byp_hit;

    assign is_zero = (src_idx == '0);
    assign byp_hit = byp_valid && (byp_idx == src_idx) && !is_zero;

    // Decide where the operand comes from.
    always_comb begin
        if (is_zero) begin
            sel = OPND_FROM_ZERO;
        end else if (byp_hit) begin
            sel = OPND_FROM_BYP;
        end else begin
            sel = OPND_FROM_RF;
        end
    end

    // Route the chosen source to the operand value.
    always_comb begin
        unique case (sel)
            OPND_FROM_ZERO: value_o = '0;
            OPND_FROM_BYP:  value_o = byp_data;
            default:        value_o = rf_data;
        endcase
    end

    assign blocked_o = !is_zero && src_busy && !byp_hit;

endmodule

// File: rtl/regrd_hazard.sv
// Module: stall decision of the register-read stage.
// Combines the write-after-write check on the destination with the
// per-source blocks and forms the issue strobe.
// Assumes the source blocks already account for bypass matches.
module regrd_hazard
    import regrd_pkg::*;
#(
    parameter int unsigned IDX_W = 5
) (
    input  logic                 in_valid,
    input  logic                 in_writes,
    input  logic [IDX_W-1:0]     dst_idx,
    input  logic                 dst_busy,
    input  logic [NUM_OPNDS-1:0] src_blocked,
    output logic                 stall_o,
    output logic                 issue_o,
    output logic                 mark_o
);

    logic waw;

    // Destination conflict only matters for instructions that write.
    always_comb begin
        waw = in_writes && (dst_idx != '0) && dst_busy;
    end

    assign stall_o = waw || (|src_blocked);
    assign issue_o = in_valid && !stall_o;
    assign mark_o  = issue_o && in_writes && (dst_idx != '0);

endmodule

// File: rtl/regrd_stage.sv
// Module: top of the register-read stage.
// Reads operands, applies scoreboard and bypass rules, and registers the
// issued instruction. Upstream holds its instruction while in_ready is low;
// downstream accepts the output register every cycle.
// Assumes writeback updates the register file at the same edge as its clear.
module regrd_stage
    import regrd_pkg::*;
#(
    parameter int unsigned NUM_REGS = 32,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned IDX_W    = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_writes,
    input  logic [IDX_W-1:0]  in_dst,
    input  logic [IDX_W-1:0]  in_src_a,
    input  logic [IDX_W-1:0]  in_src_b,
    output logic [IDX_W-1:0]  rf_addr_a,
    output logic [IDX_W-1:0]  rf_addr_b,
    input  logic [DATA_W-1:0] rf_data_a,
    input  logic [DATA_W-1:0] rf_data_b,
    input  logic              byp_valid,
    input  logic [IDX_W-1:0]  byp_idx,
    input  logic [DATA_W-1:0] byp_data,
    input  logic              wb_clr_valid,
    input  logic [IDX_W-1:0]  wb_clr_idx,
    output logic              out_valid,
    output logic              out_writes,
    output logic [IDX_W-1:0]  out_dst,
    output logic [DATA_W-1:0] out_opnd_a,
    output logic [DATA_W-1:0] out_opnd_b
);

    logic [NUM_REGS-1:0]  busy_q;
    logic [IDX_W-1:0]     src_idx   [NUM_OPNDS];
    logic [DATA_W-1:0]    src_rf    [NUM_OPNDS];
    logic [DATA_W-1:0]    src_val   [NUM_OPNDS];
    logic [NUM_OPNDS-1:0] src_block;
    logic                 stall;
    logic                 issue;
    logic                 mark;

    assign src_idx[0] = in_src_a;
    assign src_idx[1] = in_src_b;
    assign src_rf[0]  = rf_data_a;
    assign src_rf[1]  = rf_data_b;
    assign rf_addr_a  = in_src_a;
    assign rf_addr_b  = in_src_b;

    regrd_scoreboard #(
        .NUM_REGS (NUM_REGS),
        .IDX_W    (IDX_W)
    ) sb_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (mark),
        .set_idx (in_dst),
        .clr_en  (wb_clr_valid),
        .clr_idx (wb_clr_idx),
        .busy_o  (busy_q)
    );

    for (genvar k = 0; k < NUM_OPNDS; k++) begin : g_opnd
        regrd_operand #(
            .IDX_W  (IDX_W),
            .DATA_W (DATA_W)
        ) opnd_i (
            .src_idx   (src_idx[k]),
            .src_busy  (busy_q[src_idx[k]]),
            .rf_data   (src_rf[k]),
            .byp_valid (byp_valid),
            .byp_idx   (byp_idx),
            .byp_data  (byp_data),
            .value_o   (src_val[k]),
            .blocked_o (src_block[k])
        );
    end

    regrd_hazard #(
        .IDX_W (IDX_W)
    ) hz_i (
        .in_valid    (in_valid),
        .in_writes   (in_writes),
        .dst_idx     (in_dst),
        .dst_busy    (busy_q[in_dst]),
        .src_blocked (src_block),
        .stall_o     (stall),
        .issue_o     (issue),
        .mark_o      (mark)
    );

    assign in_ready = !stall;

    // Valid flag of the output register follows the issue strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= issue;
        end
    end

    // Payload of the output register loads only on issue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_writes <= 1'b0;
            out_dst    <= '0;
            out_opnd_a <= '0;
            out_opnd_b <= '0;
        end else if (issue) begin
            out_writes <= in_writes;
            out_dst    <= in_dst;
            out_opnd_a <= src_val[0];
            out_opnd_b <= src_val[1];
        end
    end

endmodule

// File: rtl/regrd_checker.sv
// Module: property checker bound to the register-read stage.
// Observes ports and the busy vector; drives nothing.
module regrd_checker #(
    parameter int unsigned NUM_REGS = 32,
    parameter int unsigned IDX_W    = $clog2(NUM_REGS)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic                in_ready,
    input logic                in_writes,
    input logic [IDX_W-1:0]    in_dst,
    input logic [IDX_W-1:0]    in_src_a,
    input logic [IDX_W-1:0]    in_src_b,
    input logic                byp_valid,
    input logic [IDX_W-1:0]    byp_idx,
    input logic                wb_clr_valid,
    input logic [IDX_W-1:0]    wb_clr_idx,
    input logic                out_valid,
    input logic [NUM_REGS-1:0] busy
);

    logic fire;
    assign fire = in_valid && in_ready;

    a_r11_valid_follows_issue: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(fire));

    a_r3_waw_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        (in_writes && in_dst != '0 && busy[in_dst]) |-> !in_ready);

    a_r4_src_a_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        (in_src_a != '0 && busy[in_src_a] && !(byp_valid && byp_idx == in_src_a)) |-> !in_ready);

    a_r4_src_b_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        (in_src_b != '0 && busy[in_src_b] && !(byp_valid && byp_idx == in_src_b)) |-> !in_ready);

    a_r8_zero_never_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !busy[0]);

    a_r2_writer_marked: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && in_writes && in_dst != '0) |=> busy[$past(in_dst)]);

    a_r10_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && in_writes && in_dst != '0 && wb_clr_valid && wb_clr_idx == in_dst)
        |=> busy[$past(in_dst)]);

    a_r9_stall_keeps_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!fire && !wb_clr_valid) |=> $stable(busy));

endmodule

bind regrd_stage regrd_checker #(
    .NUM_REGS (NUM_REGS),
    .IDX_W    (IDX_W)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .in_writes    (in_writes),
    .in_dst       (in_dst),
    .in_src_a     (in_src_a),
    .in_src_b     (in_src_b),
    .byp_valid    (byp_valid),
    .byp_idx      (byp_idx),
    .wb_clr_valid (wb_clr_valid),
    .wb_clr_idx   (wb_clr_idx),
    .out_valid    (out_valid),
    .busy         (busy_q)
);

// File: tb/regrd_stage_tb.sv
// Bench: behavioural model of the stage compared on every clock.
module regrd_stage_tb_top;

    localparam int unsigned NR     = 32;
    localparam int unsigned DW     = 32;
    localparam int unsigned IW     = 5;
    localparam time         CLK_PERIOD = 10ns;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0, in_writes = 1'b0;
    logic [IW-1:0] in_dst = '0, in_src_a = '0, in_src_b = '0;
    logic [IW-1:0] rf_addr_a, rf_addr_b;
    logic [DW-1:0] rf_data_a, rf_data_b;
    logic          byp_valid = 1'b0;
    logic [IW-1:0] byp_idx = '0;
    logic [DW-1:0] byp_data = '0;
    logic          wb_clr_valid = 1'b0;
    logic [IW-1:0] wb_clr_idx = '0;
    logic [DW-1:0] wb_data = '0;
    logic          in_ready, out_valid, out_writes;
    logic [IW-1:0] out_dst;
    logic [DW-1:0] out_opnd_a, out_opnd_b;

    // Register file stand-in: two combinational reads, one write on clear.
    logic [DW-1:0] rf_mem [NR];
    assign rf_data_a = rf_mem[rf_addr_a];
    assign rf_data_b = rf_mem[rf_addr_b];

    always #(CLK_PERIOD/2) clk = ~clk;

    regrd_stage #(.NUM_REGS(NR), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_writes(in_writes), .in_dst(in_dst), .in_src_a(in_src_a), .in_src_b(in_src_b),
        .rf_addr_a(rf_addr_a), .rf_addr_b(rf_addr_b), .rf_data_a(rf_data_a), .rf_data_b(rf_data_b),
        .byp_valid(byp_valid), .byp_idx(byp_idx), .byp_data(byp_data),
        .wb_clr_valid(wb_clr_valid), .wb_clr_idx(wb_clr_idx),
        .out_valid(out_valid), .out_writes(out_writes), .out_dst(out_dst),
        .out_opnd_a(out_opnd_a), .out_opnd_b(out_opnd_b)
    );

    // Model state.
    bit            m_busy [NR];
    bit            m_ov;
    bit            m_ow;
    int unsigned   m_od, m_oa, m_ob;
    int            n_checks = 0;
    int            n_errors = 0;
    bit            done = 1'b0;

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic bit m_blocked(input int unsigned s);
        if (s == 0) return 1'b0;
        return m_busy[s] && !(byp_valid && byp_idx == IW'(s));
    endfunction

    function automatic int unsigned m_value(input int unsigned s);
        if (s == 0) return 0;
        if (byp_valid && byp_idx == IW'(s)) return byp_data;
        return rf_mem[s];
    endfunction

    // One cycle: inputs already set; check, clock, update model.
    task automatic step(input string req);
        bit exp_ready, iss;
        #1;
        exp_ready = !((in_writes && in_dst != 0 && m_busy[in_dst]) ||
                      m_blocked(in_src_a) || m_blocked(in_src_b));
        chk(req, "in_ready", in_ready, exp_ready);
        iss = in_valid && exp_ready;
        @(posedge clk);
        if (iss) begin
            m_ow = in_writes; m_od = in_dst;
            m_oa = m_value(in_src_a); m_ob = m_value(in_src_b);
        end
        m_ov = iss;
        if (wb_clr_valid) m_busy[wb_clr_idx] = 1'b0;
        if (iss && in_writes && in_dst != 0) m_busy[in_dst] = 1'b1;
        if (wb_clr_valid && wb_clr_idx != 0) rf_mem[wb_clr_idx] <= wb_data;
        @(negedge clk);
        chk(req, "out_valid", out_valid, m_ov);
        if (m_ov) begin
            chk(req, "out_writes", out_writes, m_ow);
            chk(req, "out_dst", out_dst, m_od);
            chk(req, "out_opnd_a", out_opnd_a, m_oa);
            chk(req, "out_opnd_b", out_opnd_b, m_ob);
        end
    endtask

    task automatic instr(input bit v, input bit w, input int d, input int a, input int b);
        in_valid = v; in_writes = w; in_dst = IW'(d); in_src_a = IW'(a); in_src_b = IW'(b);
    endtask

    task automatic byp(input bit v, input int i, input int unsigned dat);
        byp_valid = v; byp_idx = IW'(i); byp_data = dat;
    endtask

    task automatic clr(input bit v, input int i, input int unsigned dat);
        wb_clr_valid = v; wb_clr_idx = IW'(i); wb_data = dat;
    endtask

    initial begin
        for (int i = 0; i < NR; i++) rf_mem[i] = (i == 0) ? 0 : 32'h1000_0000 + i * 32'h0101;
        rf_mem[0] = 32'hDEAD_0000; // R8: register 0 must still read as zero
        for (int i = 0; i < NR; i++) m_busy[i] = 1'b0;
        m_ov = 0; m_ow = 0; m_od = 0; m_oa = 0; m_ob = 0;
        repeat (3) @(negedge clk);
        chk("R1", "out_valid in reset", out_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "out_valid after reset", out_valid, 0);

        // R1/R11: first writer issues at once.
        instr(1, 1, 5, 1, 2); step("R1");
        // R2/R4: reader of r5 stalls; R9: stays stalled, nothing issues.
        instr(1, 0, 9, 5, 3); step("R2"); step("R9");
        // R5: bypass of r5 releases and supplies value.
        byp(1, 5, 32'hCAFE_0005); step("R5");
        // R6: bypass gone, r5 still busy, stall again.
        byp(0, 0, 0); instr(1, 0, 9, 3, 5); step("R6");
        // R3: writer of busy r5 stalls; non-writer naming r5 issues.
        instr(1, 1, 5, 1, 1); step("R3");
        instr(1, 0, 5, 1, 2); step("R3");
        // R7: clear r5 with new value; same cycle still stalls.
        instr(1, 0, 8, 5, 4); clr(1, 5, 32'h5555_AAAA); step("R7");
        clr(0, 0, 0); step("R7");
        // R8: dst 0 never busy, reads zero, bypass to 0 ignored.
        instr(1, 1, 0, 0, 0); step("R8");
        instr(1, 1, 0, 0, 6); byp(1, 0, 32'h1234_5678); step("R8");
        byp(0, 0, 0);
        // R5: bypass on a non-busy register still replaces the value.
        instr(1, 0, 2, 6, 7); byp(1, 7, 32'h7777_0007); step("R5");
        byp(0, 0, 0);
        // R10: make r7 busy, then mark and clear it in the same cycle.
        instr(1, 1, 7, 1, 1); step("R10");
        instr(1, 1, 10, 1, 1); clr(1, 7, 32'h0000_0777); step("R10");
        clr(0, 0, 0);
        instr(1, 1, 7, 1, 1); clr(1, 7, 32'h0000_0778); step("R10");
        clr(0, 0, 0);
        instr(1, 0, 3, 7, 2); step("R10");
        // R4: both sources busy, bypass covers only one: still stall.
        instr(1, 0, 3, 7, 10); byp(1, 7, 32'h0BAD_0007); step("R4");
        byp(0, 0, 0); instr(0, 0, 0, 0, 0); step("R11");

        // Random traffic on a small register window.
        for (int c = 0; c < 3000; c++) begin
            instr($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1,
                  $urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 7));
            byp($urandom_range(0, 2) == 0, $urandom_range(0, 7), $urandom);
            clr($urandom_range(0, 2) == 0, $urandom_range(0, 7), $urandom);
            step("R11");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule